// File: doc/BRIEF.md
# DAC Output Value Hold/Clear Gate

This block sits between a control source and a two-channel converter interface. For each channel it registers a conversion word and forwards it, forces it to zero, or freezes it. The choice depends on a system error flag and a mode bit that selects between freezing and zeroing. With no error flagged, the incoming word always passes through. With an error flagged, zeroing mode drives all zeros, and freezing mode keeps the last word that was loaded while the error flag was low.

The block also samples a conversion-value enable strobe through two flops. On each rising edge of that strobe it produces a pulse one clock wide. The same pulse goes out on two ports: one for the converter interface and one for a downstream synchronization-pulse generator.

All outputs are registered on one clock. The reset is synchronous and active low.

Top module: `dac_value_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel output becomes zero and both pulse outputs become 0 after that edge.
- R2: With `sys_err`=0 and `hold_mode`=0, each channel output equals that channel's input from the previous clock edge.
- R3: With `sys_err`=0 and `hold_mode`=1, each channel output equals that channel's input from the previous clock edge.
- R4: With `sys_err`=1 and `hold_mode`=0, each channel output is all zeros after the edge, whatever the inputs are.
- R5: With `sys_err`=1 and `hold_mode`=1, each channel output keeps its present value, and input changes have no effect on it.
- R6: On the first edge at which `sys_err` is 0 again, the outputs load the current inputs.
- R7: If `strobe_in` is sampled low at edge k-1 and high at edge k, `val_en_out` is 1 for exactly the cycle after edge k+1.
- R8: `sync_evt_out` equals `val_en_out` in every cycle.
- R9: A strobe that stays high produces only one pulse, and a falling edge produces none.
- R10: The channels are independent. Channel i of `ch_val_out` carries only channel i of `ch_val_in`, with channel i at bits [i*DATA_W +: DATA_W].
- R11: If `hold_mode` changes from 1 to 0 while `sys_err` stays 1, the frozen outputs become zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_err | input | 1 | System error flag |
| hold_mode | input | 1 | 1 = freeze on error, 0 = zero on error |
| ch_val_in | input | NUM_CH x DATA_W | Incoming conversion words, one per channel |
| strobe_in | input | 1 | Conversion-value enable strobe |
| ch_val_out | output | NUM_CH x DATA_W | Gated conversion words |
| val_en_out | output | 1 | One-cycle enable pulse on a strobe rising edge |
| sync_evt_out | output | 1 | Same pulse, for the synchronization logic |

## Verification
The bench changes the inputs on every cycle while an error is flagged in freezing mode. A design that reloads during the error would show the new words instead of the frozen one. It also checks the first cycle after the error clears, where a design with an extra cycle of hold would lag behind the inputs. It switches the mode during an error, where a design that latched the mode only when the error rose would keep the old word instead of zeroing. It drives a strobe that stays high for several cycles and then falls: a level detector would give a wide pulse, and a detector for both edges would give a second pulse on the fall. The two channels always carry different words, so swapped or shared lanes show up at once.

// File: rtl/dac_gate_pkg.sv
package dac_gate_pkg;

    // Action applied to every channel register at the next edge
    typedef enum logic [1:0] {
        ACT_LOAD = 2'd0,
        ACT_KEEP = 2'd1,
        ACT_ZERO = 2'd2
    } gate_act_e;

endpackage

// File: rtl/dac_chan_gate.sv
module dac_chan_gate
    import dac_gate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gate_act_e         act,
    input  logic [DATA_W-1:0] val_in,
    output logic [DATA_W-1:0] val_out
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD: st_d.val = val_in;
            ACT_KEEP: st_d.val = st_q.val;
            default:  st_d.val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_out = st_q.val;

endmodule

// File: rtl/dac_strobe_edge.sv
module dac_strobe_edge #(
    parameter int SYNC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);

    localparam int LAST = SYNC_W - 1;

    typedef struct packed {
        logic [SYNC_W-1:0] smp;
        logic              en;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = {st_q.smp[LAST-1:0], strobe};
        // newest sample high, the one before it low
        st_d.en  = st_q.smp[LAST-1] & ~st_q.smp[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.en;

endmodule

// File: rtl/dac_value_gate.sv
module dac_value_gate
    import dac_gate_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sys_err,
    input  logic                           hold_mode,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_val_in,
    input  logic                           strobe_in,
    output logic [NUM_CH-1:0][DATA_W-1:0]  ch_val_out,
    output logic                           val_en_out,
    output logic                           sync_evt_out
);

    gate_act_e act;
    logic      en_pulse;

    always_comb begin
        if (!sys_err) begin
            act = ACT_LOAD;
        end else if (hold_mode) begin
            act = ACT_KEEP;
        end else begin
            act = ACT_ZERO;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dac_chan_gate #(.DATA_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .act     (act),
            .val_in  (ch_val_in[c]),
            .val_out (ch_val_out[c])
        );
    end

    dac_strobe_edge #(.SYNC_W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe_in),
        .pulse  (en_pulse)
    );

    assign val_en_out   = en_pulse;
    assign sync_evt_out = en_pulse;

endmodule

// File: rtl/dac_value_gate_chk.sv
module dac_value_gate_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sys_err,
    input logic                          hold_mode,
    input logic [NUM_CH-1:0][DATA_W-1:0] ch_val_in,
    input logic [NUM_CH-1:0][DATA_W-1:0] ch_val_out,
    input logic                          val_en_out,
    input logic                          sync_evt_out
);

    logic was_rst_q;

    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (ch_val_out == '0 && !val_en_out));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sys_err)) |-> (ch_val_out == $past(ch_val_in)));

    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sys_err) && !$past(hold_mode)) |-> (ch_val_out == '0));

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sys_err) && $past(hold_mode)) |-> $stable(ch_val_out));

    p_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        val_en_out |=> !val_en_out);

    p_same_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt_out == val_en_out);

endmodule

bind dac_value_gate dac_value_gate_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_err      (sys_err),
    .hold_mode    (hold_mode),
    .ch_val_in    (ch_val_in),
    .ch_val_out   (ch_val_out),
    .val_en_out   (val_en_out),
    .sync_evt_out (sync_evt_out)
);

// File: tb/dac_value_gate_bench.sv
`timescale 1ns/1ps
module dac_value_gate_bench;

    localparam int NUM_CH = 2;
    localparam int DATA_W = 32;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic                          sys_err = 1'b0;
    logic                          hold_mode = 1'b0;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_val_in = '0;
    logic                          strobe_in = 1'b0;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_val_out;
    logic                          val_en_out;
    logic                          sync_evt_out;

    always #2.5 clk = ~clk;

    dac_value_gate #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dac_value_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_err      (sys_err),
        .hold_mode    (hold_mode),
        .ch_val_in    (ch_val_in),
        .strobe_in    (strobe_in),
        .ch_val_out   (ch_val_out),
        .val_en_out   (val_en_out),
        .sync_evt_out (sync_evt_out)
    );

    typedef struct {
        logic [NUM_CH-1:0][DATA_W-1:0] val;
        logic                          en;
        string                         vtag;
        string                         etag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // bench model state
    logic [NUM_CH-1:0][DATA_W-1:0] m_val = '0;
    logic m_s1 = 1'b0;
    logic m_s2 = 1'b0;

    task automatic step(input logic rst, input logic err, input logic hold,
                        input logic [DATA_W-1:0] v0, input logic [DATA_W-1:0] v1,
                        input logic strb, input string vtag, input string etag);
        exp_t e;
        @(negedge clk);
        rst_n        = rst;
        sys_err      = err;
        hold_mode    = hold;
        ch_val_in[0] = v0;
        ch_val_in[1] = v1;
        strobe_in    = strb;
        if (!rst) begin
            m_val = '0;
            e.en  = 1'b0;
            m_s1  = 1'b0;
            m_s2  = 1'b0;
        end else begin
            e.en = m_s1 & ~m_s2;
            if (!err) begin
                m_val[0] = v0;
                m_val[1] = v1;
            end else if (!hold) begin
                m_val = '0;
            end
            m_s2 = m_s1;
            m_s1 = strb;
        end
        e.val  = m_val;
        e.vtag = vtag;
        e.etag = etag;
        exp_q.push_back(e);
    endtask

    // monitor: compare after each edge's registers settle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                for (int c = 0; c < NUM_CH; c++) begin
                    total++;
                    if (ch_val_out[c] !== e.val[c]) begin
                        bad++;
                        $display("FAIL %s ch%0d: actual=%h expected=%h", e.vtag, c, ch_val_out[c], e.val[c]);
                    end
                end
                total++;
                if (val_en_out !== e.en) begin
                    bad++;
                    $display("FAIL %s enable: actual=%b expected=%b", e.etag, val_en_out, e.en);
                end
                total++;
                if (sync_evt_out !== e.en) begin
                    bad++;
                    $display("FAIL R8 sync: actual=%b expected=%b", sync_evt_out, e.en);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        step(0, 0, 0, 32'hAAAA_0001, 32'h5555_0001, 0, "R1", "R1");
        step(0, 0, 0, 32'hAAAA_0002, 32'h5555_0002, 0, "R1", "R1");
        // R2 pass in zeroing mode; R10 distinct lanes; strobe rises (R7)
        step(1, 0, 0, 32'h1234_5678, 32'h8765_4321, 0, "R2", "R7");
        step(1, 0, 0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1, "R10", "R7");
        step(1, 0, 0, 32'h0000_0001, 32'hFFFF_FFFF, 1, "R2", "R7");
        // R3 pass in freezing mode; strobe stays high (R9)
        step(1, 0, 1, 32'hCAFE_0000, 32'h0000_CAFE, 1, "R3", "R9");
        step(1, 0, 1, 32'h1111_2222, 32'h3333_4444, 1, "R3", "R9");
        // R5 freeze with changing inputs; strobe falls (R9)
        step(1, 1, 1, 32'h9999_9999, 32'h7777_7777, 0, "R5", "R9");
        step(1, 1, 1, 32'h0101_0101, 32'h0202_0202, 0, "R5", "R9");
        step(1, 1, 1, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, "R5", "R7");
        // R6 recovery
        step(1, 0, 1, 32'h2468_ACE0, 32'h1357_9BDF, 0, "R6", "R7");
        step(1, 0, 0, 32'h5A5A_5A5A, 32'hA5A5_A5A5, 0, "R10", "R9");
        // R4 zero on error
        step(1, 1, 0, 32'h4444_4444, 32'h8888_8888, 0, "R4", "R9");
        step(1, 1, 0, 32'h6666_6666, 32'hBBBB_BBBB, 1, "R4", "R7");
        step(1, 0, 0, 32'h0000_00FF, 32'hFF00_0000, 1, "R6", "R9");
        // R11 switch freeze -> zero during error
        step(1, 0, 1, 32'h1357_2468, 32'h8642_7531, 0, "R3", "R9");
        step(1, 1, 1, 32'hEEEE_EEEE, 32'hDDDD_DDDD, 0, "R5", "R9");
        step(1, 1, 0, 32'hEEEE_EEEE, 32'hDDDD_DDDD, 1, "R11", "R7");
        step(1, 1, 1, 32'hCCCC_CCCC, 32'h3333_3333, 0, "R11", "R7");
        step(1, 0, 0, 32'h7654_3210, 32'h0123_4567, 0, "R6", "R9");
        // R1 reset mid-run with strobe rising
        step(0, 0, 0, 32'hABCD_EF01, 32'h10FE_DCBA, 1, "R1", "R1");
        step(1, 0, 0, 32'h0000_0002, 32'h0000_0003, 1, "R2", "R9");
        step(1, 0, 0, 32'h0000_0004, 32'h0000_0005, 1, "R2", "R9");
        step(1, 0, 0, 32'h0000_0006, 32'h0000_0007, 1, "R2", "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule